// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers character frames from an asynchronous serial line. A divisor counter produces an oversampling tick. Each bit period lasts sixteen ticks, or eight when double speed is selected. The start edge is confirmed near the middle of the bit. Each later bit is resolved by a majority vote of three centre samples. The frame layout is chosen at run time: five to nine data bits sent least significant bit first, then an optional even or odd parity bit, then a stop bit. Only the first stop bit is examined, so a sender that uses two stop bits is received correctly.

A finished frame is loaded into a holding register. The register shows the low eight data bits, the ninth bit on its own output, and three error flags that belong to that character: framing, parity and overrun. A ready flag marks unread data. A read strobe clears it, and a maskable interrupt follows it. An address-filter mode discards every frame whose last data bit is 0. In that mode, only frames with that bit at 1 reach the holding register.

Top module: `serial_rx_core`

## Requirements
- R1: `len_sel` picks the data length: 0..4 give 5..9 bits, and values 5..7 give 8 bits. Data arrive least significant bit first. `rx_data` holds the low eight received bits, and bits at or above the data length read 0.
- R2: `rx_bit8` shows the ninth received data bit in 9-bit frames and is 0 for shorter frames.
- R3: The oversampling tick fires once every `divisor`+1 clocks. A bit lasts 16 ticks with `double_speed`=0 and 8 ticks with `double_speed`=1.
- R4: `parity_mode` 2'b10 is even parity and 2'b11 is odd parity, each with one parity bit after the data. With 2'b00 or 2'b01 no parity bit is sent. `err_parity` is set when the received parity bit does not match the selected mode, and it is always 0 when parity is off.
- R5: `err_frame` is set when the first stop bit is sampled as 0.
- R6: `rx_ready` goes to 1 in the cycle after a frame is accepted and stays at 1 until a cycle with `rd_strobe`=1, after which it reads 0.
- R7: If a frame is accepted while `rx_ready`=1 and no read happens in that cycle, the new frame replaces the data and `err_overrun` is 1. Otherwise `err_overrun` is 0 for the new frame.
- R8: `rx_data`, `rx_bit8` and the three error flags change only when a frame is accepted. A read does not clear them.
- R9: `irq` is 1 exactly when `rx_ready`=1 and `irq_enable`=1.
- R10: While `rx_enable`=0 no frame is received, and a frame in progress is abandoned.
- R11: With `mp_filter`=1, a frame whose last data bit (bit 8 in 9-bit frames) is 0 is discarded and changes nothing. A frame whose last data bit is 1 is accepted.
- R12: A low pulse on the line that is shorter than half a bit does not start a frame.
- R13: A one-clock spike inside a bit does not change that bit, because of the three-sample majority vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Receiver enable |
| double_speed | input | 1 | 8 ticks per bit instead of 16 |
| divisor | input | 16 | Tick period minus one, in clocks |
| len_sel | input | 3 | Data length select |
| parity_mode | input | 2 | Parity select |
| mp_filter | input | 1 | Address-filter mode |
| irq_enable | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Read of the holding register |
| rx_data | output | 8 | Received data, low eight bits |
| rx_bit8 | output | 1 | Ninth received data bit |
| rx_ready | output | 1 | Unread data present |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | Previous character was not read |
| err_parity | output | 1 | Parity mismatch |
| irq | output | 1 | Receive interrupt |

## Verification
The line passes through a two-flop synchroniser. The frame is then accepted at the last vote sample of the stop bit, which is about two clocks plus half a bit after the stop edge. The holding register updates on the clock edge after that. The bench therefore drives a whole frame plus three idle bit times before it samples `rx_ready`, the data and the flags, always on a falling edge. A read strobe lasts one cycle and is checked one falling edge later, and `irq` is checked in the same cycle as `rx_ready`. Each rejected-input case is judged by `rx_ready` remaining 0 after the full frame time, or by the decoded data.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [8:0] data;
        logic       addr_bit;
        logic       stop_ok;
        logic       par_err;
    } frame_t;

    function automatic logic [3:0] bits_for_sel(input logic [2:0] sel);
        return (sel <= 3'd4) ? ({1'b0, sel} + 4'd5) : 4'd8;
    endfunction

endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick   = (st_q.cnt >= divisor);
        st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int unsigned OVS_LOG2    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       enable,
    input  logic       tick,
    input  logic       double_speed,
    input  logic [2:0] len_sel,
    input  logic [1:0] parity_mode,
    output logic       frame_end,
    output frame_t     frame
);
    localparam int unsigned CNT_W = OVS_LOG2;
    localparam logic [CNT_W-1:0] LAST_N = '1;
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'((2 ** (OVS_LOG2 - 1)) - 1);
    localparam logic [CNT_W-1:0] MID_N  = CNT_W'(2 ** (OVS_LOG2 - 1));
    localparam logic [CNT_W-1:0] MID_D  = CNT_W'(2 ** (OVS_LOG2 - 2));

    typedef struct packed {
        rx_state_e              state;
        logic [CNT_W-1:0]       cnt;
        logic [3:0]             bit_idx;
        logic [1:0]             votes;
        logic [8:0]             shift;
        logic                   par_bit;
        logic [SYNC_STAGES-1:0] sync;
    } smp_st_t;

    smp_st_t st_d, st_q;

    logic             line;
    logic             vote;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] mid_cnt;
    logic [CNT_W-1:0] first_cnt;
    logic [CNT_W-1:0] decide_cnt;
    logic [3:0]       nbits;
    logic             par_en;

    always_comb begin
        st_d       = st_q;
        line       = st_q.sync[SYNC_STAGES-1];
        last_cnt   = double_speed ? LAST_D : LAST_N;
        mid_cnt    = double_speed ? MID_D : MID_N;
        first_cnt  = mid_cnt - 1'b1;
        decide_cnt = mid_cnt + 1'b1;
        nbits      = bits_for_sel(len_sel);
        par_en     = parity_mode[1];
        vote       = (st_q.votes[0] & st_q.votes[1]) |
                     (st_q.votes[0] & line) |
                     (st_q.votes[1] & line);

        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], rx_line};

        frame_end      = 1'b0;
        frame.data     = st_q.shift;
        frame.addr_bit = st_q.shift[nbits - 4'd1];
        frame.stop_ok  = vote;
        frame.par_err  = par_en & (st_q.par_bit ^ (^st_q.shift) ^ parity_mode[0]);

        if (!enable) begin
            st_d.state = ST_IDLE;
        end else if (tick) begin
            if (st_q.state == ST_IDLE) begin
                if (!line) begin
                    st_d.state   = ST_START;
                    st_d.cnt     = {{(CNT_W-1){1'b0}}, 1'b1};
                    st_d.bit_idx = '0;
                    st_d.shift   = '0;
                    st_d.par_bit = 1'b0;
                end
            end else begin
                st_d.cnt = (st_q.cnt == last_cnt) ? '0 : st_q.cnt + 1'b1;
                if (st_q.cnt == first_cnt) st_d.votes[0] = line;
                if (st_q.cnt == mid_cnt)   st_d.votes[1] = line;
                if (st_q.cnt == decide_cnt) begin
                    unique case (st_q.state)
                        ST_START:  if (vote) st_d.state = ST_IDLE;
                        ST_DATA:   st_d.shift[st_q.bit_idx] = vote;
                        ST_PARITY: st_d.par_bit = vote;
                        ST_STOP: begin
                            frame_end  = 1'b1;
                            st_d.state = ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (st_q.cnt == last_cnt) begin
                    unique case (st_q.state)
                        ST_START: begin
                            st_d.state   = ST_DATA;
                            st_d.bit_idx = '0;
                        end
                        ST_DATA: begin
                            if (st_q.bit_idx == nbits - 4'd1)
                                st_d.state = par_en ? ST_PARITY : ST_STOP;
                            else
                                st_d.bit_idx = st_q.bit_idx + 4'd1;
                        end
                        ST_PARITY: st_d.state = ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.sync  <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/srx_result_reg.sv
module srx_result_reg
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_end,
    input  frame_t     frame,
    input  logic       mp_filter,
    input  logic       rd_strobe,
    output logic       commit,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rx_ready,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       err_parity
);
    typedef struct packed {
        logic [7:0] data;
        logic       b8;
        logic       ready;
        logic       fe;
        logic       dor;
        logic       pe;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = frame_end & (~mp_filter | frame.addr_bit);
        if (rd_strobe) st_d.ready = 1'b0;
        if (commit) begin
            st_d.data  = frame.data[7:0];
            st_d.b8    = frame.data[8];
            st_d.fe    = ~frame.stop_ok;
            st_d.pe    = frame.par_err;
            st_d.dor   = st_q.ready & ~rd_strobe;
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data     = st_q.data;
    assign rx_bit8     = st_q.b8;
    assign rx_ready    = st_q.ready;
    assign err_frame   = st_q.fe;
    assign err_overrun = st_q.dor;
    assign err_parity  = st_q.pe;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned OVS_LOG2    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             rx_enable,
    input  logic             double_speed,
    input  logic [DIV_W-1:0] divisor,
    input  logic [2:0]       len_sel,
    input  logic [1:0]       parity_mode,
    input  logic             mp_filter,
    input  logic             irq_enable,
    input  logic             rd_strobe,
    output logic [7:0]       rx_data,
    output logic             rx_bit8,
    output logic             rx_ready,
    output logic             err_frame,
    output logic             err_overrun,
    output logic             err_parity,
    output logic             irq
);
    logic   tick;
    logic   frame_end;
    logic   commit;
    frame_t frame;

    srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    srx_sampler #(.OVS_LOG2(OVS_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_line      (rx_line),
        .enable       (rx_enable),
        .tick         (tick),
        .double_speed (double_speed),
        .len_sel      (len_sel),
        .parity_mode  (parity_mode),
        .frame_end    (frame_end),
        .frame        (frame)
    );

    srx_result_reg u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (frame_end),
        .frame       (frame),
        .mp_filter   (mp_filter),
        .rd_strobe   (rd_strobe),
        .commit      (commit),
        .rx_data     (rx_data),
        .rx_bit8     (rx_bit8),
        .rx_ready    (rx_ready),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .err_parity  (err_parity)
    );

    assign irq = rx_ready & irq_enable;
endmodule

// File: rtl/serial_rx_core_checker.sv
module serial_rx_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_enable,
    input logic       irq_enable,
    input logic       rd_strobe,
    input logic       commit,
    input logic [7:0] rx_data,
    input logic       rx_bit8,
    input logic       rx_ready,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       irq
);
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |-> !irq);
    p_irq_raised_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && irq_enable) |-> irq);
    p_commit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_ready);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !commit) |=> !rx_ready);
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rx_ready && !rd_strobe) |=> err_overrun);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({rx_data, rx_bit8, err_frame, err_parity, err_overrun}));
    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !$rose(rx_ready));
endmodule

bind serial_rx_core serial_rx_core_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .irq_enable  (irq_enable),
    .rd_strobe   (rd_strobe),
    .commit      (commit),
    .rx_data     (rx_data),
    .rx_bit8     (rx_bit8),
    .rx_ready    (rx_ready),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .irq         (irq)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // fields: len[23:21] par[20:19] dbl[18] div[17:14] data[13:5] badstop[4] badpar[3] two[2] mp[1] spare[0]
    localparam logic [23:0] VEC [NVEC] = '{
        {3'd3, 2'b00, 1'b0, 4'd0, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd0, 2'b10, 1'b0, 4'd0, 9'h1F3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd1, 2'b11, 1'b0, 4'd0, 9'h02A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd2, 2'b10, 1'b0, 4'd0, 9'h05B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd4, 2'b00, 1'b0, 4'd0, 9'h1C3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd4, 2'b11, 1'b0, 4'd0, 9'h055, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd3, 2'b00, 1'b0, 4'd0, 9'h0E1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd3, 2'b00, 1'b1, 4'd2, 9'h03C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd7, 2'b10, 1'b0, 4'd1, 9'h081, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd4, 2'b00, 1'b0, 4'd0, 9'h1AA, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {3'd3, 2'b00, 1'b0, 4'd0, 9'h07F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {3'd3, 2'b11, 1'b0, 4'd0, 9'h080, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        rx_enable = 1'b1;
    logic        double_speed = 1'b0;
    logic [15:0] divisor = '0;
    logic [2:0]  len_sel = 3'd3;
    logic [1:0]  parity_mode = 2'b00;
    logic        mp_filter = 1'b0;
    logic        irq_enable = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_bit8, rx_ready, err_frame, err_overrun, err_parity, irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx_core uut (
        .clk, .rst_n, .rx_line, .rx_enable, .double_speed, .divisor, .len_sel,
        .parity_mode, .mp_filter, .irq_enable, .rd_strobe, .rx_data, .rx_bit8,
        .rx_ready, .err_frame, .err_overrun, .err_parity, .irq
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] sel);
        return (sel <= 3'd4) ? int'(sel) + 5 : 8;
    endfunction

    task automatic drive_bit(input logic v, input int bitclk, input bit spike);
        rx_line = v;
        if (spike) begin
            repeat (bitclk / 2) @(negedge clk);
            rx_line = ~v;
            @(negedge clk);
            rx_line = v;
            repeat (bitclk / 2 - 1) @(negedge clk);
        end else begin
            repeat (bitclk) @(negedge clk);
        end
    endtask

    // sends a frame with the current configuration; spike_idx marks a data bit to disturb
    task automatic send_frame(input logic [8:0] d, input bit bad_stop, input bit bad_par,
                              input bit two, input int spike_idx);
        int  n      = nbits_of(len_sel);
        int  bitclk = (double_speed ? 8 : 16) * (int'(divisor) + 1);
        logic px    = 1'b0;
        drive_bit(1'b0, bitclk, 1'b0);
        for (int i = 0; i < n; i++) begin
            drive_bit(d[i], bitclk, i == spike_idx);
            px = px ^ d[i];
        end
        if (parity_mode[1]) drive_bit(px ^ parity_mode[0] ^ bad_par, bitclk, 1'b0);
        drive_bit(~bad_stop, bitclk, 1'b0);
        if (two) drive_bit(1'b1, bitclk, 1'b0);
        rx_line = 1'b1;
        repeat (3 * bitclk) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R6 read clears ready", 32'(rx_ready), 32'd0);
    endtask

    task automatic cfg(input logic [2:0] l, input logic [1:0] p, input logic dbl,
                       input logic [15:0] dv, input logic mp);
        @(negedge clk);
        len_sel = l; parity_mode = p; double_speed = dbl; divisor = dv; mp_filter = mp;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset ready", 32'(rx_ready), 32'd0);
        check("R8 reset flags", 32'({err_frame, err_overrun, err_parity}), 32'd0);
        check("R1 reset data", 32'(rx_data), 32'd0);
        check("R9 reset irq", 32'(irq), 32'd0);

        // table walk: R1 R2 R3 R4 R5 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e = VEC[v];
            int  n;
            bit  drop;
            logic [8:0] d;
            logic [8:0] mask;
            cfg(e[23:21], e[20:19], e[18], {12'd0, e[17:14]}, e[1]);
            n    = nbits_of(e[23:21]);
            d    = e[13:5];
            mask = 9'((1 << n) - 1);
            drop = e[1] && (d[n-1] == 1'b0);
            send_frame(d, e[4], e[3], e[2], -1);
            if (drop) begin
                check("R11 dropped frame ready", 32'(rx_ready), 32'd0);
            end else begin
                check("R6 ready after frame", 32'(rx_ready), 32'd1);
                check("R1 R3 data", 32'(rx_data), 32'(d[7:0] & mask[7:0]));
                check("R2 ninth bit", 32'(rx_bit8), (n == 9) ? 32'(d[8]) : 32'd0);
                check("R5 framing flag", 32'(err_frame), 32'(e[4]));
                check("R4 parity flag", 32'(err_parity), 32'(e[20] & e[3]));
                check("R7 no overrun", 32'(err_overrun), 32'd0);
                check("R9 irq with ready", 32'(irq), 32'd1);
                do_read();
            end
        end

        // R7 overrun and R8 persistence
        cfg(3'd3, 2'b00, 1'b0, 16'd0, 1'b0);
        send_frame(9'h011, 1'b0, 1'b0, 1'b0, -1);
        send_frame(9'h022, 1'b0, 1'b0, 1'b0, -1);
        check("R7 overrun data replaced", 32'(rx_data), 32'h22);
        check("R7 overrun flag", 32'(err_overrun), 32'd1);
        do_read();
        check("R8 overrun kept after read", 32'(err_overrun), 32'd1);
        send_frame(9'h033, 1'b0, 1'b0, 1'b0, -1);
        check("R7 overrun cleared on clean frame", 32'(err_overrun), 32'd0);
        do_read();

        // R8 framing flag persists
        send_frame(9'h044, 1'b1, 1'b0, 1'b0, -1);
        repeat (100) @(negedge clk);
        check("R8 framing flag held", 32'(err_frame), 32'd1);
        do_read();
        check("R8 framing flag after read", 32'(err_frame), 32'd1);
        check("R8 data after read", 32'(rx_data), 32'h44);

        // R9 interrupt mask
        irq_enable = 1'b0;
        send_frame(9'h055, 1'b0, 1'b0, 1'b0, -1);
        check("R9 ready while masked", 32'(rx_ready), 32'd1);
        check("R9 irq masked", 32'(irq), 32'd0);
        @(negedge clk);
        irq_enable = 1'b1;
        @(negedge clk);
        check("R9 irq unmasked", 32'(irq), 32'd1);
        do_read();

        // R10 receiver disabled
        rx_enable = 1'b0;
        send_frame(9'h066, 1'b0, 1'b0, 1'b0, -1);
        check("R10 disabled no ready", 32'(rx_ready), 32'd0);
        check("R10 disabled data kept", 32'(rx_data), 32'h55);
        rx_enable = 1'b1;
        send_frame(9'h067, 1'b0, 1'b0, 1'b0, -1);
        check("R10 re-enabled data", 32'(rx_data), 32'h67);
        do_read();

        // R12 short low glitch
        @(negedge clk);
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (300) @(negedge clk);
        check("R12 glitch ignored", 32'(rx_ready), 32'd0);

        // R13 spike in a data bit
        send_frame(9'h000, 1'b0, 1'b0, 1'b0, 3);
        check("R13 spike voted out ready", 32'(rx_ready), 32'd1);
        check("R13 spike voted out data", 32'(rx_data), 32'h00);
        do_read();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule